// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a behavioural, synthesizable model of a small synchronous static RAM with a shared data bus, written so that reads and writes can alternate on consecutive clocks without idle cycles. Every control input and the address are sampled on the rising clock, but only on edges where the active-low clock enable is low. A read presents the addressed word combinationally in the cycle that follows the edge that registered its address. A write takes its data one enabled edge later, and a new access can be started on that same edge.

The bidirectional bus is split into a data input, a data output and an output-enable signal, so that a pad ring or a bench can rebuild the shared bus. Each word holds several 9-bit lanes of 8 data bits and 1 parity bit. Each lane has its own active-low write strobe. An internal burst generator steps through a block of four words from a single loaded address, in linear or interleaved order. The order is chosen when the address is loaded.

Top module: `fsram_top`

## Requirements
- R1: While `rst` is high on a clock edge, any access in progress is dropped, and after that edge `dout_en` is low.
- R2: A rising edge with `cen_n` high changes no state. The active access, the burst position and any pending write data phase all keep their values, so the output word and `dout_en` stay the same.
- R3: An access starts on an edge with `cen_n` low, `ld_n` low and every bit of `csel_n` low. `we_n` low selects a write and `we_n` high selects a read.
- R4: After an edge that starts or continues a read, `dout` shows the stored word at the current address, and `dout_en` is high if `oe_n` is low.
- R5: `oe_n` acts on `dout_en` combinationally, with no clock edge needed. `dout_en` is never high while `oe_n` is high.
- R6: The data of a write is taken from `din` on the next edge with `cen_n` low. An access started on that same edge already sees the new data.
- R7: In the data phase of a write, `dout_en` is low whatever the level of `oe_n`.
- R8: Lane i is bits [9i+8:9i] of the word. It is written only if `bw_n[i]` was low on the edge that registered that write beat's address. Other lanes keep their stored contents.
- R9: An edge with `cen_n` low, `ld_n` low and any bit of `csel_n` high is a deselect, and after that edge `dout_en` is low.
- R10: An edge with `cen_n` low and `ld_n` high advances an active burst. The two low address bits are base+n modulo 4 when `burst_il` was 0 at load, and base XOR n when it was 1. Here n is the number of advances. The upper address bits do not change.
- R11: On burst continuation edges, `csel_n` and `we_n` are ignored, and the access keeps the read or write type that was set at load.
- R12: Each beat of a burst write samples `bw_n` again on its own address edge.
- R13: After a deselect or reset, an edge with `ld_n` high does not start an access, and `dout_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Active-low clock qualifier |
| csel_n | input | NSEL (3) | Active-low chip selects, all must be low to start an access |
| ld_n | input | 1 | Low: load a new address; high: advance the burst |
| we_n | input | 1 | Low: write access; high: read access (sampled at load) |
| bw_n | input | LANES (2) | Active-low per-lane write strobes |
| burst_il | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | AW (6) | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | LANES*LANE_W (18) | Write data from the bus |
| dout | output | LANES*LANE_W (18) | Read data to the bus |
| dout_en | output | 1 | High when the block drives the bus |

## Verification
The assertions assume that `rst` is high on the first clock edge, so that the access state is defined before any property leaves its disable. They also assume that the parameters keep at least one address bit above the burst field. Apart from that they allow any input pattern, because each property speaks only about the edge after a sampled command. The bench keeps every input at a known value from time zero. It changes inputs only at the falling edge, so each command is fully set up before the edge that samples it. During stalls it keeps driving the pending write data, so a write data phase that is held over a stall still receives the intended word.

// File: rtl/fsram_pkg.sv
package fsram_pkg;

    // Command decoded from the sampled control inputs of one clock edge
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,   // clock enable inactive: nothing moves
        CMD_LOAD  = 2'd1,   // new address with all selects active
        CMD_DESEL = 2'd2,   // load cycle with a select inactive
        CMD_ADV   = 2'd3    // burst continuation
    } cmd_e;

    // State of the access currently owning the array port
    typedef struct packed {
        logic valid;    // an access is active
        logic write;    // the active access is a write
        logic il;       // burst order: 1 interleaved, 0 linear
    } acc_t;

    function automatic cmd_e classify(input logic cen_n, input logic ld_n,
                                      input logic sel_ok);
        cmd_e c;
        if (cen_n)       c = CMD_HOLD;
        else if (ld_n)   c = CMD_ADV;
        else if (sel_ok) c = CMD_LOAD;
        else             c = CMD_DESEL;
        return c;
    endfunction

endpackage

// File: rtl/fsram_seq.sv
module fsram_seq
    import fsram_pkg::*;
#(
    parameter int NSEL  = 3,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cen_n,
    input  logic [NSEL-1:0]  csel_n,
    input  logic             ld_n,
    input  logic             we_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             burst_il,
    output cmd_e             cmd,
    output acc_t             acc,
    output logic [LANES-1:0] lane_en
);

    logic sel_ok;

    assign sel_ok = (csel_n == '0);
    assign cmd    = classify(cen_n, ld_n, sel_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            lane_en <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    acc.valid <= 1'b1;
                    acc.write <= ~we_n;
                    acc.il    <= burst_il;
                    lane_en   <= ~bw_n;
                end
                CMD_DESEL: begin
                    acc.valid <= 1'b0;
                    acc.write <= 1'b0;
                    lane_en   <= '0;
                end
                CMD_ADV: begin
                    // type is kept; strobes are sampled again for each beat
                    if (acc.valid) lane_en <= ~bw_n;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fsram_burst.sv
module fsram_burst
    import fsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_e          cmd,
    input  logic          active,
    input  logic          il,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] cur_addr
);

    logic [AW-1:0] base_q;
    logic [BW-1:0] step_q;
    logic [BW-1:0] low_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            step_q <= '0;
        end else if (cmd == CMD_LOAD) begin
            base_q <= addr;
            step_q <= '0;
        end else if (cmd == CMD_ADV && active) begin
            step_q <= step_q + 1'b1;
        end
    end

    always_comb begin
        if (il) low_bits = base_q[BW-1:0] ^ step_q;
        else    low_bits = base_q[BW-1:0] + step_q;
    end

    assign cur_addr = {base_q[AW-1:BW], low_bits};

endmodule

// File: rtl/fsram_array.sv
module fsram_array #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      commit,
    input  logic [LANES-1:0]          lane_en,
    input  logic [$clog2(DEPTH)-1:0]  waddr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [$clog2(DEPTH)-1:0]  raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);

    localparam int WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (commit && lane_en[g])
                mem[waddr][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fsram_top.sv
module fsram_top
    import fsram_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int LANES     = 2,
    parameter int LANE_W    = 9,
    parameter int NSEL      = 3,
    parameter int BURST_LEN = 4,
    localparam int AW       = $clog2(DEPTH),
    localparam int WORD_W   = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic [NSEL-1:0]   csel_n,
    input  logic              ld_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              burst_il,
    input  logic [AW-1:0]     addr,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    localparam int BW = $clog2(BURST_LEN);

    cmd_e             cmd;
    acc_t             acc;
    logic [LANES-1:0] lane_en;
    logic [AW-1:0]    cur_addr;
    logic             acc_valid;
    logic             acc_write;
    logic             commit;

    fsram_seq #(.NSEL(NSEL), .LANES(LANES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cen_n    (cen_n),
        .csel_n   (csel_n),
        .ld_n     (ld_n),
        .we_n     (we_n),
        .bw_n     (bw_n),
        .burst_il (burst_il),
        .cmd      (cmd),
        .acc      (acc),
        .lane_en  (lane_en)
    );

    assign acc_valid = acc.valid;
    assign acc_write = acc.write;

    fsram_burst #(.AW(AW), .BW(BW)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .active   (acc_valid),
        .il       (acc.il),
        .addr     (addr),
        .cur_addr (cur_addr)
    );

    // write data phase completes on the next enabled edge
    assign commit = !rst && !cen_n && acc_valid && acc_write;

    fsram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .commit  (commit),
        .lane_en (lane_en),
        .waddr   (cur_addr),
        .wdata   (din),
        .raddr   (cur_addr),
        .rdata   (dout)
    );

    assign dout_en = acc_valid && !acc_write && !oe_n;

endmodule

// File: rtl/fsram_checker.sv
module fsram_checker #(
    parameter int AW   = 6,
    parameter int NSEL = 3,
    parameter int BW   = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            cen_n,
    input logic            ld_n,
    input logic [NSEL-1:0] csel_n,
    input logic            we_n,
    input logic            oe_n,
    input logic            dout_en,
    input logic            acc_valid,
    input logic            acc_write,
    input logic [AW-1:0]   cur_addr
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !dout_en);

    a_r2_hold_state: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> ($stable(acc_valid) && $stable(acc_write) && $stable(cur_addr)));

    a_r3_load_type: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !ld_n && csel_n == '0) |=> (acc_valid && acc_write == !$past(we_n)));

    a_r5_oe_gates: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> !oe_n);

    a_r7_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !ld_n && csel_n == '0 && !we_n) |=> !dout_en);

    a_r9_deselect: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !ld_n && csel_n != '0) |=> (!dout_en && !acc_valid));

    a_r10_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && ld_n && acc_valid) |=> (cur_addr[AW-1:BW] == $past(cur_addr[AW-1:BW])));

    a_r11_type_held: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && ld_n && acc_valid) |=> (acc_valid && acc_write == $past(acc_write)));

    a_r13_no_restart: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && ld_n && !acc_valid) |=> (!acc_valid && !dout_en));

endmodule

bind fsram_top fsram_checker #(.AW(AW), .NSEL(NSEL), .BW(BW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cen_n     (cen_n),
    .ld_n      (ld_n),
    .csel_n    (csel_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .dout_en   (dout_en),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .cur_addr  (cur_addr)
);

// File: tb/fsram_top_bench.sv
module fsram_top_bench;

    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int WW    = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cen_n = 1'b0;
    logic [2:0]    csel_n = 3'b000;
    logic          ld_n = 1'b0;
    logic          we_n = 1'b1;
    logic [1:0]    bw_n = 2'b00;
    logic          burst_il = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          oe_n = 1'b0;
    logic [WW-1:0] din = '0;
    logic [WW-1:0] dout;
    logic          dout_en;

    int errors = 0;
    int checks = 0;
    logic [WW-1:0] exp_mem [DEPTH];

    fsram_top u_fsram_top (
        .clk(clk), .rst(rst), .cen_n(cen_n), .csel_n(csel_n), .ld_n(ld_n),
        .we_n(we_n), .bw_n(bw_n), .burst_il(burst_il), .addr(addr),
        .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #4 clk = ~clk;

    function automatic logic [WW-1:0] pattern(input int a);
        return WW'((a * 32'h1357 + 32'h2a5) ^ (a << 11));
    endfunction

    function automatic logic [WW-1:0] merge(input logic [WW-1:0] old_w,
                                            input logic [WW-1:0] new_w,
                                            input logic [1:0] strobe_n);
        logic [WW-1:0] r;
        r = old_w;
        if (!strobe_n[0]) r[8:0]  = new_w[8:0];
        if (!strobe_n[1]) r[17:9] = new_w[17:9];
        return r;
    endfunction

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base,
                                                input int n, input logic il);
        logic [1:0] lo;
        lo = il ? (base[1:0] ^ 2'(n)) : (base[1:0] + 2'(n));
        return {base[AW-1:2], lo};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic l, input logic [2:0] s,
                         input logic w, input logic [1:0] b,
                         input logic [AW-1:0] a, input logic [WW-1:0] d);
        cen_n = c; ld_n = l; csel_n = s; we_n = w; bw_n = b; addr = a; din = d;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [WW-1:0] d;
        logic [1:0] bseq [4];
        logic [WW-1:0] wseq [4];
        void'($urandom(32'h5eed_0042));

        // R1: reset
        @(negedge clk);
        drive(0, 0, 3'b000, 1, 2'b00, 6'd3, '0);
        repeat (3) tick();
        chk("R1 dout_en under reset", dout_en, 0);
        rst = 1'b0;
        drive(0, 1, 3'b000, 1, 2'b00, 6'd3, '0);
        tick();
        chk("R13 advance after reset", dout_en, 0);

        // fill every word with back-to-back writes
        for (int a = 0; a <= DEPTH; a++) begin
            if (a < DEPTH)
                drive(0, 0, 3'b000, 0, 2'b00, AW'(a), (a == 0) ? '0 : pattern(a - 1));
            else
                drive(0, 0, 3'b111, 1, 2'b00, '0, pattern(a - 1));
            tick();
            if (a < DEPTH) exp_mem[a] = pattern(a);
        end

        // R4 flow-through read
        drive(0, 0, 3'b000, 1, 2'b11, 6'd5, '0);
        tick();
        chk("R4 read enable", dout_en, 1);
        chk("R4 read data", dout, exp_mem[5]);

        // R5 asynchronous output enable
        oe_n = 1'b1; #1;
        chk("R5 oe high blocks", dout_en, 0);
        oe_n = 1'b0; #1;
        chk("R5 oe low drives", dout_en, 1);

        // R2 stalled edge keeps the read
        drive(1, 0, 3'b000, 0, 2'b00, 6'd9, '0);
        tick();
        chk("R2 stall keeps data", dout, exp_mem[5]);
        chk("R2 stall keeps enable", dout_en, 1);

        // R2 stall holds the write data phase
        drive(0, 0, 3'b000, 0, 2'b00, 6'd10, '0);
        tick();
        drive(1, 0, 3'b000, 1, 2'b00, 6'd10, 18'h3ffff);
        tick();
        d = 18'h1a2b3;
        drive(0, 0, 3'b000, 1, 2'b00, 6'd10, d);
        exp_mem[10] = d;
        tick();
        chk("R2 write after stall", dout, exp_mem[10]);

        // R7 and R6 write then read the same word
        drive(0, 0, 3'b000, 0, 2'b00, 6'd12, '0);
        tick();
        chk("R7 write phase quiet", dout_en, 0);
        d = 18'h2c0de;
        drive(0, 0, 3'b000, 1, 2'b00, 6'd12, d);
        exp_mem[12] = d;
        tick();
        chk("R6 back to back read", dout, d);
        chk("R6 read enable", dout_en, 1);

        // R8 lane strobes
        drive(0, 0, 3'b000, 0, 2'b01, 6'd13, '0);
        tick();
        d = 18'h15a5a;
        drive(0, 0, 3'b000, 0, 2'b10, 6'd14, d);
        exp_mem[13] = merge(exp_mem[13], d, 2'b01);
        tick();
        d = 18'h0f00f;
        drive(0, 0, 3'b000, 1, 2'b00, 6'd13, d);
        exp_mem[14] = merge(exp_mem[14], d, 2'b10);
        tick();
        chk("R8 upper lane only", dout, exp_mem[13]);
        drive(0, 0, 3'b000, 1, 2'b00, 6'd14, '0);
        tick();
        chk("R8 lower lane only", dout, exp_mem[14]);

        // R9 each select deselects; R13 no restart on advance
        for (int i = 0; i < 3; i++) begin
            drive(0, 0, 3'b000, 1, 2'b00, 6'd20, '0);
            tick();
            chk("R9 read before deselect", dout_en, 1);
            drive(0, 0, 3'(1 << i), 1, 2'b00, 6'd20, '0);
            tick();
            chk("R9 deselect", dout_en, 0);
        end
        for (int i = 0; i < 2; i++) begin
            drive(0, 1, 3'b000, 1, 2'b00, 6'd20, '0);
            tick();
            chk("R13 advance after deselect", dout_en, 0);
        end

        // R10 / R11 burst reads, linear then interleaved
        for (int m = 0; m < 2; m++) begin
            logic [AW-1:0] base;
            base = (m == 0) ? 6'd22 : 6'd41;
            burst_il = 1'(m);
            drive(0, 0, 3'b000, 1, 2'b00, base, '0);
            tick();
            burst_il = 1'b0;
            chk("R10 burst first beat", dout, exp_mem[base]);
            for (int n = 1; n <= 4; n++) begin
                drive(0, 1, 3'b111, 0, 2'b00, 6'd0, '0);
                tick();
                chk("R10 burst beat data", dout, exp_mem[beat_addr(base, n, 1'(m))]);
                chk("R11 read type held", dout_en, 1);
            end
        end

        // R12 burst write with a fresh strobe per beat
        bseq[0] = 2'b00; bseq[1] = 2'b01; bseq[2] = 2'b10; bseq[3] = 2'b11;
        for (int n = 0; n < 4; n++) wseq[n] = pattern(100 + n);
        drive(0, 0, 3'b000, 0, bseq[0], 6'd50, '0);
        tick();
        for (int n = 1; n <= 4; n++) begin
            if (n < 4) drive(0, 1, 3'b111, 1, bseq[n], 6'd0, wseq[n-1]);
            else       drive(0, 0, 3'b111, 1, 2'b00, 6'd0, wseq[n-1]);
            exp_mem[beat_addr(6'd50, n-1, 1'b0)] =
                merge(exp_mem[beat_addr(6'd50, n-1, 1'b0)], wseq[n-1], bseq[n-1]);
            tick();
            chk("R11 write type held", dout_en, 0);
        end
        for (int n = 0; n < 4; n++) begin
            drive(0, 0, 3'b000, 1, 2'b00, beat_addr(6'd50, n, 1'b0), '0);
            tick();
            chk("R12 burst write beat", dout, exp_mem[beat_addr(6'd50, n, 1'b0)]);
        end

        // random single accesses mixed with stalls and deselects
        begin
            logic          pend = 1'b0;
            logic [AW-1:0] p_addr = '0;
            logic [1:0]    p_bw = '0;
            logic [WW-1:0] p_data = '0;
            logic          last_en = 1'b1;
            logic [WW-1:0] last_dout = dout;
            for (int it = 0; it < 600; it++) begin
                int op;
                logic [AW-1:0] a;
                logic [WW-1:0] dd;
                op = $urandom_range(0, 3);
                a  = AW'($urandom_range(0, DEPTH - 1));
                dd = pend ? p_data : WW'($urandom);
                if (op == 3) begin
                    drive(1, 1'($urandom), 3'($urandom), 1'($urandom), 2'($urandom), a, dd);
                    tick();
                    chk("R2 random stall enable", dout_en, last_en);
                    if (last_en) chk("R2 random stall data", dout, last_dout);
                end else begin
                    if (pend) begin
                        exp_mem[p_addr] = merge(exp_mem[p_addr], p_data, p_bw);
                        pend = 1'b0;
                    end
                    if (op == 0) begin
                        drive(0, 0, 3'b000, 1, 2'($urandom), a, dd);
                        tick();
                        last_en = 1'b1;
                        last_dout = exp_mem[a];
                        chk("R4 random read enable", dout_en, 1);
                        chk("R4 random read data", dout, exp_mem[a]);
                    end else if (op == 1) begin
                        logic [1:0] b;
                        b = 2'($urandom);
                        drive(0, 0, 3'b000, 0, b, a, dd);
                        tick();
                        pend = 1'b1; p_addr = a; p_bw = b; p_data = WW'($urandom);
                        last_en = 1'b0;
                        chk("R7 random write quiet", dout_en, 0);
                    end else begin
                        drive(0, 0, 3'($urandom_range(1, 7)), 1'($urandom), 2'b00, a, dd);
                        tick();
                        last_en = 1'b0;
                        chk("R9 random deselect", dout_en, 0);
                    end
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule